// File: doc/BRIEF.md
# Dual-Scheme Serial Clock Divider

This block derives the serial-clock timing of an SPI shift engine from a faster module clock. A 13-bit clock-control word selects one of two division schemes. In the linear scheme the serial clock runs at the module clock divided by 2·(N+1), where N is an 8-bit field. In the power-of-two scheme it runs at the module clock divided by 2^M, where M is a 4-bit field. Configuration software picks the linear scheme when the divisor it needs fits in the 8-bit field, and falls back to the power-of-two scheme when it does not. The serial clock can never run faster than half the module clock.

The shift engine raises `burst_active` for the length of a burst. While that input is low, the divider counter is held cleared and `sclk` rests at the idle level that `cpol` selects. On the first cycle of a burst the block samples the control word and the polarity. From then on it issues one-cycle strobes, first a leading-edge strobe and then a trailing-edge strobe, one every half period. `sclk` toggles in the same cycle as each strobe. A control word or polarity that changes during a burst takes effect only when the next burst starts.

The sequencer has three states: `CK_IDLE`, `CK_LEAD_WAIT` and `CK_TRAIL_WAIT`.
- `CK_IDLE` moves to `CK_LEAD_WAIT` on burst start, which is also when the configuration is captured.
- `CK_LEAD_WAIT` moves to `CK_TRAIL_WAIT` on a half-period tick and issues a leading strobe.
- `CK_TRAIL_WAIT` moves to `CK_LEAD_WAIT` on a tick and issues a trailing strobe.
- Either waiting state returns to `CK_IDLE` when `burst_active` is sampled low.

Top module: `spiclk_div`

## Requirements
- R1: During and right after reset, both strobes are low and `sclk` equals `cpol`.
- R2: With `clk_ctl[12]`=1, consecutive strobes are N+1 module clocks apart, where N=`clk_ctl[7:0]`. This gives an `sclk` period of 2·(N+1) clocks. `clk_ctl[11:8]` is ignored in this scheme.
- R3: With `clk_ctl[12]`=0 and M=`clk_ctl[11:8]`≥1, consecutive strobes are 2^(M-1) clocks apart, for an `sclk` period of 2^M clocks. `clk_ctl[7:0]` is ignored in this scheme.
- R4: With `clk_ctl[12]`=0 and M=0, strobes come on every clock, which limits the period to 2 clocks.
- R5: While `burst_active` is low, no strobe is issued and `sclk` follows `cpol`, including changes to `cpol` made while idle.
- R6: If the clock edge that first samples `burst_active` high is edge E, and the half period is H, then the first strobe is a leading one and is visible after edge E+H.
- R7: Strobes last one cycle, are never both high at once, and alternate strictly leading, trailing, leading, and so on.
- R8: `sclk` toggles exactly in strobe cycles. After a leading strobe it equals the inverse of the captured polarity, and after a trailing strobe it equals the captured polarity.
- R9: Changing `clk_ctl` or `cpol` during a burst changes neither the strobe timing nor the `sclk` level of that burst. The new values apply from the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_active | input | 1 | High for the length of a burst; low holds the divider |
| cpol | input | 1 | Idle level of the serial clock |
| clk_ctl | input | 13 | [7:0] linear N, [11:8] power exponent M, [12] scheme select (1 = linear) |
| lead_stb | output | 1 | One-cycle strobe at each leading serial-clock edge |
| trail_stb | output | 1 | One-cycle strobe at each trailing serial-clock edge |
| sclk | output | 1 | Serial clock level |

## Verification
The properties assume that `cpol` and `burst_active` change only away from the active clock edge. Under that assumption the polarity captured at burst start is the same value that `sclk` showed in the idle cycle before it. The level-stability property relies on this. The bench drives every input on the falling edge. It keeps each burst open for a whole number of cycles, and it changes configuration inputs only on those falling edges, both inside and between bursts.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    typedef enum logic [1:0] {
        CK_IDLE       = 2'd0,
        CK_LEAD_WAIT  = 2'd1,
        CK_TRAIL_WAIT = 2'd2
    } ck_state_e;

endpackage

// File: rtl/spiclk_cfg_hold.sv
// Captures scheme, divisor and polarity at burst start and converts the
// divisor fields into a half-period length in module clocks.
module spiclk_cfg_hold #(
    parameter int N_W = 8,
    parameter int M_W = 4,
    parameter int H_W = 15,
    localparam int CTL_W = N_W + M_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic             cpol_in,
    output logic [H_W-1:0]   half_len,
    output logic             cpol_held
);

    logic           use_linear;
    logic [N_W-1:0] n_fld;
    logic [M_W-1:0] m_fld;
    logic [H_W-1:0] lin_half;
    logic [H_W-1:0] pow_half;

    assign use_linear = ctl_word[CTL_W-1];
    assign n_fld      = ctl_word[N_W-1:0];
    assign m_fld      = ctl_word[N_W+M_W-1:N_W];

    always_comb begin
        lin_half = H_W'(n_fld) + H_W'(1);
        if (m_fld == '0) begin
            pow_half = H_W'(1);
        end else begin
            pow_half = H_W'(1) << (m_fld - M_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_len  <= H_W'(1);
            cpol_held <= 1'b0;
        end else if (load) begin
            half_len  <= use_linear ? lin_half : pow_half;
            cpol_held <= cpol_in;
        end
    end

endmodule

// File: rtl/spiclk_tick_cnt.sv
// Half-period counter: cleared while stopped, ticks once every half_len clocks.
module spiclk_tick_cnt #(
    parameter int H_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [H_W-1:0] half_len,
    output logic           tick
);

    logic [H_W-1:0] count_q;

    assign tick = run && (count_q == (half_len - H_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + H_W'(1);
        end
    end

endmodule

// File: rtl/spiclk_edge_fsm.sv
// Sequencer: alternates leading and trailing strobes and drives the clock level.
module spiclk_edge_fsm
    import spiclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burst,
    input  logic tick,
    input  logic cpol_live,
    input  logic cpol_held,
    output logic load,
    output logic running,
    output logic lead_stb,
    output logic trail_stb,
    output logic sclk
);

    ck_state_e state_q;
    ck_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_IDLE: begin
                if (burst) state_d = CK_LEAD_WAIT;
            end
            CK_LEAD_WAIT: begin
                if (!burst)     state_d = CK_IDLE;
                else if (tick)  state_d = CK_TRAIL_WAIT;
            end
            CK_TRAIL_WAIT: begin
                if (!burst)     state_d = CK_IDLE;
                else if (tick)  state_d = CK_LEAD_WAIT;
            end
            default: state_d = CK_IDLE;
        endcase
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            lead_stb  <= burst && tick && (state_q == CK_LEAD_WAIT);
            trail_stb <= burst && tick && (state_q == CK_TRAIL_WAIT);
        end
    end

    assign load    = (state_q == CK_IDLE) && burst;
    assign running = (state_q != CK_IDLE);
    assign sclk    = (state_q == CK_IDLE) ? cpol_live
                                          : (cpol_held ^ (state_q == CK_TRAIL_WAIT));

endmodule

// File: rtl/spiclk_div.sv
module spiclk_div #(
    parameter int N_W = 8,
    parameter int M_W = 4,
    localparam int CTL_W = N_W + M_W + 1,
    localparam int LIN_W = N_W + 1,
    localparam int POW_W = (1 << M_W) - 1,
    localparam int H_W   = (LIN_W > POW_W) ? LIN_W : POW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_active,
    input  logic             cpol,
    input  logic [CTL_W-1:0] clk_ctl,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             sclk
);

    logic           load;
    logic           running;
    logic           tick;
    logic           cpol_held;
    logic [H_W-1:0] half_len;

    spiclk_cfg_hold #(.N_W(N_W), .M_W(M_W), .H_W(H_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ctl_word  (clk_ctl),
        .cpol_in   (cpol),
        .half_len  (half_len),
        .cpol_held (cpol_held)
    );

    spiclk_tick_cnt #(.H_W(H_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .half_len (half_len),
        .tick     (tick)
    );

    spiclk_edge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst     (burst_active),
        .tick      (tick),
        .cpol_live (cpol),
        .cpol_held (cpol_held),
        .load      (load),
        .running   (running),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .sclk      (sclk)
    );

endmodule

// File: rtl/spiclk_div_chk.sv
module spiclk_div_chk (
    input logic clk,
    input logic rst_n,
    input logic burst_active,
    input logic cpol,
    input logic lead_stb,
    input logic trail_stb,
    input logic sclk
);

    // remembers whether the most recent strobe in this burst was a leading one
    logic last_was_lead;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             last_was_lead <= 1'b0;
        else if (lead_stb)      last_was_lead <= 1'b1;
        else if (trail_stb)     last_was_lead <= 1'b0;
        else if (!burst_active) last_was_lead <= 1'b0;
    end

    // R5: once a low burst_active has been seen, the outputs are idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!burst_active) |-> (!lead_stb && !trail_stb && sclk == cpol));

    // R7: strobes never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R7: a leading strobe is never repeated without a trailing one between
    a_r7_lead_first: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> !last_was_lead);

    // R7: a trailing strobe always follows a leading one
    a_r7_trail_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> last_was_lead);

    // R8: each strobe comes with a change of the clock level
    a_r8_toggle_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

    // R8: during a burst the level changes only with a strobe
    a_r8_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(burst_active) && !lead_stb && !trail_stb) |-> $stable(sclk));

endmodule

bind spiclk_div spiclk_div_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_active (burst_active),
    .cpol         (cpol),
    .lead_stb     (lead_stb),
    .trail_stb    (trail_stb),
    .sclk         (sclk)
);

// File: tb/tb_spiclk_div.sv
`timescale 1ns/1ps
module tb_spiclk_div;

    localparam int CTL_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             burst_active = 1'b0;
    logic             cpol = 1'b0;
    logic [CTL_W-1:0] clk_ctl = '0;
    logic             lead_stb;
    logic             trail_stb;
    logic             sclk;

    spiclk_div dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .cpol         (cpol),
        .clk_ctl      (clk_ctl),
        .lead_stb     (lead_stb),
        .trail_stb    (trail_stb),
        .sclk         (sclk)
    );

    always #2 clk = ~clk;   // 4 ns period

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit    lead;
        int    at;
        bit    lvl;
        string req;
    } exp_t;

    exp_t q[$];
    int   nvec  = 0;
    int   nfail = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int half_of(input logic [CTL_W-1:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        if (c[11:8] == 4'd0) return 1;
        return 1 << (int'(c[11:8]) - 1);
    endfunction

    // monitor: pop and compare each strobe as it appears
    always @(negedge clk) begin
        if (rst_n && (lead_stb || trail_stb)) begin
            nvec++;
            if (q.size() == 0) begin
                nfail++;
                $display("FAIL R7 unexpected strobe at cycle %0d: actual %0d expected 0",
                         cyc, 1);
            end else begin
                exp_t e;
                bit   bad;
                e   = q.pop_front();
                bad = 1'b0;
                if (lead_stb != e.lead || lead_stb == trail_stb) begin
                    bad = 1'b1;
                    $display("FAIL R7 strobe kind (lead) at cycle %0d: actual %0d expected %0d",
                             cyc, lead_stb, e.lead);
                end
                if (cyc != e.at) begin
                    bad = 1'b1;
                    $display("FAIL %s strobe cycle: actual %0d expected %0d", e.req, cyc, e.at);
                end
                if (sclk != e.lvl) begin
                    bad = 1'b1;
                    $display("FAIL R8 sclk level at cycle %0d: actual %0d expected %0d",
                             cyc, sclk, e.lvl);
                end
                if (bad) nfail++;
            end
        end
    end

    // driver: one burst; optional change of inputs after 'chg' cycles
    task automatic run_burst(input logic [CTL_W-1:0] c, input bit p, input int ncyc,
                             input logic [CTL_W-1:0] c2, input bit p2, input int chg,
                             input string req);
        int h;
        int t0;
        clk_ctl      = c;
        cpol         = p;
        burst_active = 1'b1;
        t0 = cyc + 1;
        h  = half_of(c);
        for (int k = 1; t0 + k * h <= t0 + ncyc - 1; k++) begin
            exp_t e;
            e.lead = (k % 2) == 1;
            e.at   = t0 + k * h;
            e.lvl  = e.lead ? ~p : p;
            e.req  = (k == 1) ? "R6" : ((chg > 0) ? "R9" : req);
            q.push_back(e);
        end
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (i == chg) begin
                clk_ctl = c2;
                cpol    = p2;
            end
        end
        burst_active = 1'b0;
        repeat (2) @(negedge clk);
        chk(q.size() == 0, req, "expected strobes left unseen", q.size(), 0);
        chk(sclk == cpol, "R5", "idle sclk level", sclk, cpol);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!lead_stb && !trail_stb, "R1", "strobes in reset", {lead_stb, trail_stb}, 0);
        chk(sclk == cpol, "R1", "sclk in reset", sclk, cpol);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lead_stb && !trail_stb && sclk == 1'b0, "R1", "state after reset",
            {lead_stb, trail_stb, sclk}, 0);

        // R5: idle sclk follows polarity, no strobes appear while idle
        cpol = 1'b1;
        clk_ctl = 13'h1000;
        repeat (5) @(negedge clk);
        chk(sclk == 1'b1, "R5", "idle sclk after polarity change", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R5", "idle sclk after polarity change back", sclk, 0);

        // R2: linear scheme, M field must be ignored
        run_burst({1'b1, 4'h0, 8'd0},   1'b0, 20,   '0, 1'b0, 0, "R2");
        run_burst({1'b1, 4'hF, 8'd3},   1'b1, 40,   '0, 1'b0, 0, "R2");
        run_burst({1'b1, 4'h5, 8'd9},   1'b0, 70,   '0, 1'b0, 0, "R2");
        run_burst({1'b1, 4'h0, 8'd255}, 1'b1, 1100, '0, 1'b0, 0, "R2");

        // R4: power scheme with M=0, N field must be ignored
        run_burst({1'b0, 4'h0, 8'hAA},  1'b0, 20,   '0, 1'b0, 0, "R4");
        run_burst({1'b0, 4'h0, 8'h00},  1'b1, 9,    '0, 1'b0, 0, "R4");

        // R3: power scheme with several exponents
        run_burst({1'b0, 4'h1, 8'h55},  1'b0, 16,   '0, 1'b0, 0, "R3");
        run_burst({1'b0, 4'h2, 8'h00},  1'b1, 30,   '0, 1'b0, 0, "R3");
        run_burst({1'b0, 4'h3, 8'hFF},  1'b0, 50,   '0, 1'b0, 0, "R3");
        run_burst({1'b0, 4'h6, 8'h00},  1'b1, 200,  '0, 1'b0, 0, "R3");
        run_burst({1'b0, 4'h9, 8'h01},  1'b0, 1100, '0, 1'b0, 0, "R3");

        // R9: change divisor and polarity mid-burst, then use them next burst
        run_burst({1'b1, 4'h0, 8'd4},   1'b0, 60, {1'b0, 4'h2, 8'd0}, 1'b1, 13, "R9");
        run_burst({1'b0, 4'h2, 8'd0},   1'b1, 30, '0, 1'b0, 0, "R9");
        run_burst({1'b0, 4'h1, 8'd0},   1'b1, 25, {1'b1, 4'h0, 8'd7}, 1'b0, 2, "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule